// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a virtual address into a physical address. The virtual address is split into a page number and an in-page offset. The page number is compared against every stored entry at once. On a match the stored physical page number is joined to the unchanged offset. Each entry holds a page tag, a physical page number and a two-bit permission field, plus valid, referenced and modified flags. A lookup reports hit or miss. It also flags an access that the entry's permissions forbid.

On a permitted hit, hardware marks the entry as referenced, and a store also marks it modified. A one-cycle clear command drops every referenced flag at once. Software can issue it periodically, which turns the flags into an approximate recency record. An external page walker or software loads new entries through a refill port. The slot to overwrite is chosen by the block and shown on `victim_idx`. The page walk itself lies outside the block.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss and `victim_idx` is 0.
- R2: The low OFF_W bits of `lk_vaddr` are the page offset and the rest is the page number. On a hit, `lk_paddr` is the entry's physical page number concatenated above the unchanged offset, in the same cycle as the request. On a miss `lk_paddr` is 0.
- R3: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high. `lk_hit` is high when some valid entry's tag equals the page number, and any entry may hold any page.
- R4: When several valid entries match, the lowest-numbered one supplies the translation and flags.
- R5: Permission bit 1 allows loads and bit 0 allows stores. A hit whose access kind is not allowed raises `lk_fault` together with `lk_hit`, and it changes neither the referenced nor the modified flag.
- R6: A permitted hit sets the entry's referenced flag from the next clock edge, and a permitted store also sets its modified flag. `lk_used` and `lk_dirty` show the matching entry's flags as they stood before the access.
- R7: `use_clear` clears every referenced flag at the next edge. A permitted hit in the same cycle still sets its own entry's flag.
- R8: `fill_valid` writes the tag, physical page number and permissions into entry `victim_idx` at the next edge. It marks that entry valid and clears its referenced and modified flags, overriding any hit update to the same entry.
- R9: `victim_idx` is the lowest-numbered invalid entry. If every entry is valid, it is the lowest-numbered entry whose referenced flag is clear. If every referenced flag is set, it is 0.
- R10: With `lk_valid` low, `lk_hit`, `lk_miss`, `lk_fault`, `lk_used` and `lk_dirty` are 0, `lk_paddr` is 0, and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_store | input | 1 | Request is a store (else a load) |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | No valid entry matched |
| lk_fault | output | 1 | Hit, but the access kind is not permitted |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| lk_used | output | 1 | Referenced flag of the matching entry |
| lk_dirty | output | 1 | Modified flag of the matching entry |
| use_clear | input | 1 | Clear all referenced flags |
| fill_valid | input | 1 | Refill write request |
| fill_vpn | input | VA_W-OFF_W | Page tag to load |
| fill_ppn | input | PPN_W | Physical page number to load |
| fill_prot | input | 2 | Permissions to load (bit 1 load, bit 0 store) |
| victim_idx | output | log2(ENTRIES) | Entry the next refill will overwrite |

## Verification
Hit, miss, fault, the physical address and the pre-access flags are combinational. They are due in the same cycle as the request, so the bench samples them 1 ns after driving inputs and before the next rising edge. Flag changes, refills and clears land at the next rising edge. They become visible only in the following cycle, through `lk_used`, `lk_dirty`, the translation and `victim_idx`. The behavioural model therefore applies every state change after that edge, never in the cycle of the request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    // width of the permission field and the meaning of its bits
    localparam int PROT_W  = 2;
    localparam int PROT_RD = 1;
    localparam int PROT_WR = 0;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 64,
    parameter int TAG_W = 20,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [N-1:0]            valid,
    input  logic [TAG_W-1:0]        key,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);
    logic [N-1:0] eq;

    // one comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    // lowest matching index wins
    always_comb begin
        any_hit = |eq;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     used,
    output logic [IDX_W-1:0] victim
);
    logic [N-1:0]     free_v;
    logic [N-1:0]     stale_v;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] stale_idx;

    assign free_v  = ~valid;
    assign stale_v = ~used;

    always_comb begin
        free_idx  = '0;
        stale_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_v[i])  free_idx  = IDX_W'(i);
            if (stale_v[i]) stale_idx = IDX_W'(i);
        end
        if (|free_v)       victim = free_idx;
        else if (|stale_v) victim = stale_idx;
        else               victim = '0;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 64,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_store,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_used,
    output logic              lk_dirty,
    input  logic              use_clear,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PROT_W-1:0] fill_prot,
    output logic [IDX_W-1:0]  victim_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [ENTRIES-1:0][PROT_W-1:0] prot;
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             used;
        logic [ENTRIES-1:0]             dirty;
    } tbl_t;

    tbl_t st_d, st_q;

    logic [VPN_W-1:0]  key;
    logic [OFF_W-1:0]  off;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [PROT_W-1:0] hit_prot;

    assign key = lk_vaddr[VA_W-1:OFF_W];
    assign off = lk_vaddr[OFF_W-1:0];

    xlat_match #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_match (
        .tags    (st_q.tag),
        .valid   (st_q.vld),
        .key     (key),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid  (st_q.vld),
        .used   (st_q.used),
        .victim (victim_idx)
    );

    assign hit_prot = st_q.prot[hit_idx];
    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_fault = lk_hit && (lk_store ? !hit_prot[PROT_WR] : !hit_prot[PROT_RD]);
    assign lk_paddr = lk_hit ? {st_q.ppn[hit_idx], off} : '0;
    assign lk_used  = lk_hit && st_q.used[hit_idx];
    assign lk_dirty = lk_hit && st_q.dirty[hit_idx];

    always_comb begin
        st_d = st_q;
        if (use_clear) st_d.used = '0;
        if (lk_hit && !lk_fault) begin
            st_d.used[hit_idx] = 1'b1;
            if (lk_store) st_d.dirty[hit_idx] = 1'b1;
        end
        if (fill_valid) begin
            st_d.tag[victim_idx]   = fill_vpn;
            st_d.ppn[victim_idx]   = fill_ppn;
            st_d.prot[victim_idx]  = fill_prot;
            st_d.vld[victim_idx]   = 1'b1;
            st_d.used[victim_idx]  = 1'b0;
            st_d.dirty[victim_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss}) == 1);

    // R5
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R5
    fault_keeps_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault && !fill_valid |=> st_q.dirty[$past(hit_idx)] == $past(st_q.dirty[hit_idx]));

    // R6
    hit_marks_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && !lk_fault && !fill_valid |=> st_q.used[$past(hit_idx)]);

    // R7
    clear_all_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_clear && !lk_valid |=> st_q.used == '0);

    // R8
    fill_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> st_q.vld[$past(victim_idx)] && !st_q.used[$past(victim_idx)]
                       && !st_q.dirty[$past(victim_idx)]);

    // R9
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~st_q.vld != '0) |-> !st_q.vld[victim_idx]);
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_store = 0, use_clear = 0, fill_valid = 0;
    logic [31:0] lk_vaddr = '0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic [1:0]  fill_prot = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_used, lk_dirty;
    logic [31:0] lk_paddr;
    logic [5:0]  victim_idx;

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_vld[N], m_tag[N], m_ppn[N], m_prot[N], m_use[N], m_dty[N];
    // snapshot of the last sampled outputs
    logic s_hit, s_miss, s_fault, s_used, s_dirty;
    logic [31:0] s_paddr;
    int s_victim;

    always #2.5 clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_store(lk_store),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr), .lk_used(lk_used), .lk_dirty(lk_dirty),
        .use_clear(use_clear), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_prot(fill_prot), .victim_idx(victim_idx)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int model_hit(input int vpn);
        for (int i = 0; i < N; i++) if (m_vld[i] != 0 && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < N; i++) if (m_vld[i] == 0) return i;
        for (int i = 0; i < N; i++) if (m_use[i] == 0) return i;
        return 0;
    endfunction

    // one clock cycle: drive, sample, compare, then advance the model past the edge
    task automatic cyc(input bit lv, input bit st, input int vpn, input int off,
                       input bit clr, input bit fv, input int fvpn, input int fppn,
                       input int fprot);
        int h, v;
        bit e_fault;
        lk_valid = lv; lk_store = st; lk_vaddr = {vpn[19:0], off[11:0]};
        use_clear = clr; fill_valid = fv; fill_vpn = fvpn[19:0];
        fill_ppn = fppn[19:0]; fill_prot = fprot[1:0];
        #1;
        h = lv ? model_hit(vpn) : -1;
        v = model_victim();
        e_fault = (h >= 0) && (st ? (m_prot[h] & 1) == 0 : (m_prot[h] & 2) == 0);
        s_hit = lk_hit; s_miss = lk_miss; s_fault = lk_fault; s_paddr = lk_paddr;
        s_used = lk_used; s_dirty = lk_dirty; s_victim = int'(victim_idx);
        check("R3 hit", lk_hit, h >= 0);
        check("R3 miss", lk_miss, lv && h < 0);
        check("R2 paddr", lk_paddr, (h >= 0) ? {m_ppn[h][19:0], off[11:0]} : 32'h0);
        check("R5 fault", lk_fault, e_fault);
        check("R6 used", lk_used, (h >= 0) ? m_use[h] : 0);
        check("R6 dirty", lk_dirty, (h >= 0) ? m_dty[h] : 0);
        check("R9 victim", victim_idx, v);
        @(posedge clk);
        if (clr) for (int i = 0; i < N; i++) m_use[i] = 0;
        if (h >= 0 && !e_fault) begin
            m_use[h] = 1;
            if (st) m_dty[h] = 1;
        end
        if (fv) begin
            m_vld[v] = 1; m_tag[v] = fvpn; m_ppn[v] = fppn; m_prot[v] = fprot;
            m_use[v] = 0; m_dty[v] = 0;
        end
        @(negedge clk);
    endtask

    task automatic look(input bit st, input int vpn);
        cyc(1, st, vpn, 'h5a5, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input int vpn, input int ppn, input int prot);
        cyc(0, 0, 0, 0, 0, 1, vpn, ppn, prot);
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_prot[i] = 0; m_use[i] = 0; m_dty[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        look(0, 'h123);
        check("R1 miss after reset", s_miss, 1);
        check("R1 victim after reset", s_victim, 0);

        // R8: fills land in successive free slots
        fill('h100, 'hA0000, 3);
        fill('h101, 'hA0001, 2);
        look(0, 'h101);
        check("R8 filled translation", s_paddr, 32'hA00015a5);
        check("R8 next free slot", s_victim, 2);

        // R5: read-only entry refuses a store, modified flag stays clear
        look(1, 'h101);
        check("R5 store fault", s_fault, 1);
        look(0, 'h101);
        check("R5 dirty untouched", s_dirty, 0);

        // R6: permitted store marks modified
        look(1, 'h100);
        look(0, 'h100);
        check("R6 dirty after store", s_dirty, 1);
        check("R6 used after hit", s_used, 1);

        // R10: idle lookup port reports nothing
        cyc(0, 1, 'h100, 0, 0, 0, 0, 0, 0);
        check("R10 idle hit", s_hit, 0);
        check("R10 idle miss", s_miss, 0);

        // R4: duplicate tag, lower slot wins
        fill('h100, 'hBBBBB, 3);
        look(0, 'h100);
        check("R4 lowest match", s_paddr, 32'hA00005a5);

        // R9: fill the rest, then steer the victim with referenced flags
        for (int i = 3; i < N; i++) fill('h200 + i, 'hC0000 + i, 3);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        for (int i = 3; i < 9; i++) look(0, 'h200 + i);
        look(0, 'h100);
        look(0, 'h101);
        look(0, 'h100);
        check("R9 lowest stale", s_victim, 2);
        for (int i = 9; i < N; i++) look(0, 'h200 + i);
        fill('h300, 'hD0000, 3);
        look(0, 'h300);
        check("R9 refill at stale slot", s_hit, 1);
        look(0, 'h300);
        check("R9 all referenced gives 0", s_victim, 0);

        // R7: clear while a hit sets its own flag
        cyc(1, 0, 'h205, 0, 1, 0, 0, 0, 0);
        look(0, 'h205);
        check("R7 concurrent hit kept", s_used, 1);
        look(0, 'h100);
        check("R7 others cleared", s_used, 0);

        // mixed random traffic, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            cyc(r < 70, $urandom_range(0, 1), $urandom_range(0, 79) + 'h280,
                $urandom_range(0, 4095), $urandom_range(0, 99) < 3, r >= 60,
                $urandom_range(0, 79) + 'h280, $urandom_range(0, 'hFFFFF),
                $urandom_range(0, 3));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule